// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous requester and a byte-wide asynchronous static RAM. Each accepted request is a single-beat read or write. The controller turns it into a correctly timed sequence on the memory pins: the address, two chip selects of opposite polarity, an output-enable strobe, a write strobe, and a split data bus with a drive enable for the external tristate buffer.

Every minimum the memory imposes is a nanosecond parameter. Each one is converted to a count of system clock cycles by ceiling division against `CLK_PERIOD_NS`. The conversion happens at elaboration, so the same RTL fits any clock rate. The address is held for the whole cycle.

The controller never drives the data bus while the memory might still be driving it. The memory can be driving it during a read, and also for the high-Z delay after the output enable is removed. Read data returns with a one-cycle valid pulse, and `ready_o` shows when a new request can be taken.

Top module: `sram_cycle_ctl`

## Requirements
- R1: During and right after reset, `ready_o`=1 and `rvalid_o`=0. The memory pins are idle: `mem_ce1_n_o`=1, `mem_ce2_o`=0, `mem_oe_n_o`=1, `mem_we_n_o`=1 and `mem_dout_en_o`=0.
- R2: The memory is selected only during an access cycle. Selected means `mem_ce1_n_o`=0 with `mem_ce2_o`=1. Whenever `ready_o` is high, it is deselected (`mem_ce1_n_o`=1, `mem_ce2_o`=0).
- R3: A read keeps the memory selected, with `mem_oe_n_o`=0 and `mem_we_n_o`=1, for exactly N_RD cycles. N_RD is the largest of the cycle counts for read cycle time, address access time and OE access time (11 at 5 ns). `mem_din_i` is captured at the end of the last of those cycles, and `rvalid_o` is high for exactly one cycle with that byte on `rdata_o`.
- R4: A write selects the memory with `mem_we_n_o` high for N_SU cycles. It then holds `mem_we_n_o` low for N_WP cycles, and then keeps the memory selected for N_REC cycles with `mem_we_n_o` high. N_WP is the larger of the pulse-width and data-setup counts (8). N_SU is max(1, address-to-end count − N_WP) (2). N_REC is max(1, write-cycle count − N_SU − N_WP) (1).
- R5: `mem_dout_en_o` is high only while `mem_we_n_o` is low and in the single cycle after it rises. Throughout the low pulse, `mem_dout_o` carries the request's write data. It is never high together with `mem_oe_n_o`=0.
- R6: After a read, `mem_dout_en_o` stays low until at least N_HZ cycles after `mem_oe_n_o` rises (N_HZ = 4, the high-Z delay). A write requested during that window waits.
- R7: `mem_addr_o` does not change while the memory stays selected.
- R8: `ready_o` is high only when idle. A request is taken when `req_i` and `ready_o` are both high. `req_i` is ignored while `ready_o` is low, and no access results from it.
- R9: Each nanosecond minimum becomes ceil(ns / `CLK_PERIOD_NS`) cycles, with at least one cycle for any nonzero value. The cycle counts in R3, R4 and R6 follow from this rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, taken when ready_o is high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 19 | Request byte address |
| wdata_i | input | 8 | Write data |
| ready_o | output | 1 | Idle, able to take a request |
| rvalid_o | output | 1 | One-cycle pulse, rdata_o valid |
| rdata_o | output | 8 | Read data |
| mem_addr_o | output | 19 | Memory address |
| mem_ce1_n_o | output | 1 | Chip select, active low |
| mem_ce2_o | output | 1 | Chip select, active high |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write strobe, active low |
| mem_dout_o | output | 8 | Data toward memory |
| mem_dout_en_o | output | 1 | Drive enable for the data bus |
| mem_din_i | input | 8 | Data from memory |

## Verification
Two situations are hard to reach from the ports. One is a write that lands inside the high-Z window left by the preceding read. The bench reaches it by issuing a write on the first cycle `ready_o` returns after a read. Its memory model keeps driving the bus for the delay after the output enable rises, and flags any cycle in which both sides drive. The other is a request raised while the block is busy. The bench pulses a write to a fresh address on the cycle right after an accepted write, then reads that address back to show it was never written. The model also returns a junk byte until the full access time has passed, so a read window that is too short shows up as a data miscompare.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WSETUP,
    ST_WPULSE,
    ST_WREC
  } ctl_state_e;

  // ns minimum -> cycles, ceiling, at least 1 for nonzero
  function automatic int ns_to_cyc(input int ns, input int period);
    int c;
    if (ns <= 0) return 0;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_downcnt.sv
module sram_ctl_downcnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_req_reg.sv
module sram_ctl_req_reg #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (take_i) begin
      we_o    <= we_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end
endmodule

// File: rtl/sram_cycle_ctl.sv
module sram_cycle_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 5,
  parameter int T_RC_NS       = 55,
  parameter int T_AA_NS       = 55,
  parameter int T_OE_NS       = 30,
  parameter int T_WC_NS       = 55,
  parameter int T_WP_NS       = 40,
  parameter int T_AW_NS       = 50,
  parameter int T_DW_NS       = 25,
  parameter int T_HZ_NS       = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce1_n_o,
  output logic              mem_ce2_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic [DATA_W-1:0] mem_dout_o,
  output logic              mem_dout_en_o,
  input  logic [DATA_W-1:0] mem_din_i
);
  localparam int N_RD  = max2(max2(ns_to_cyc(T_RC_NS, CLK_PERIOD_NS),
                                   ns_to_cyc(T_AA_NS, CLK_PERIOD_NS)),
                              max2(ns_to_cyc(T_OE_NS, CLK_PERIOD_NS), 1));
  localparam int N_WP  = max2(max2(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                   ns_to_cyc(T_DW_NS, CLK_PERIOD_NS)), 1);
  localparam int N_SU  = max2(ns_to_cyc(T_AW_NS, CLK_PERIOD_NS) - N_WP, 1);
  localparam int N_REC = max2(ns_to_cyc(T_WC_NS, CLK_PERIOD_NS) - N_SU - N_WP, 1);
  localparam int N_HZ  = ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS);
  localparam int N_MAX = max2(max2(N_RD, N_WP), max2(max2(N_SU, N_REC), N_HZ));
  localparam int CW    = $clog2(N_MAX + 1);

  ctl_state_e state_q, state_d;
  logic              take;
  logic              rq_we;
  logic [DATA_W-1:0] rq_wdata;
  logic              ph_load, ph_zero;
  logic [CW-1:0]     ph_val;
  logic              ta_load, ta_zero, ta_busy;
  logic              sel;
  logic              dout_en_q;
  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;

  assign take = req_i && (state_q == ST_IDLE);

  sram_ctl_req_reg #(.AW(ADDR_W), .DW(DATA_W)) u_req (
    .clk_i, .rst_ni,
    .take_i (take),
    .we_i, .addr_i, .wdata_i,
    .we_o   (rq_we),
    .addr_o (mem_addr_o),
    .wdata_o(rq_wdata)
  );

  sram_ctl_downcnt #(.W(CW)) u_phase (
    .clk_i, .rst_ni,
    .load_i    (ph_load),
    .load_val_i(ph_val),
    .zero_o    (ph_zero)
  );

  // bus release window after OE is removed
  sram_ctl_downcnt #(.W(CW)) u_turn (
    .clk_i, .rst_ni,
    .load_i    (ta_load),
    .load_val_i(CW'(N_HZ)),
    .zero_o    (ta_zero)
  );
  assign ta_busy = !ta_zero;

  always_comb begin
    state_d = state_q;
    ph_load = 1'b0;
    ph_val  = '0;
    ta_load = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        if (!we_i) begin
          state_d = ST_READ;   ph_load = 1'b1; ph_val = CW'(N_RD - 1);
        end else if (ta_busy) begin
          state_d = ST_TURN;
        end else begin
          state_d = ST_WSETUP; ph_load = 1'b1; ph_val = CW'(N_SU - 1);
        end
      end
      ST_TURN: if (!ta_busy) begin
        state_d = ST_WSETUP; ph_load = 1'b1; ph_val = CW'(N_SU - 1);
      end
      ST_READ: if (ph_zero) begin
        state_d = ST_IDLE; ta_load = 1'b1;
      end
      ST_WSETUP: if (ph_zero) begin
        state_d = ST_WPULSE; ph_load = 1'b1; ph_val = CW'(N_WP - 1);
      end
      ST_WPULSE: if (ph_zero) begin
        state_d = ST_WREC;   ph_load = 1'b1; ph_val = CW'(N_REC - 1);
      end
      ST_WREC: if (ph_zero) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      dout_en_q <= 1'b0;
      rvalid_q  <= 1'b0;
      rdata_q   <= '0;
    end else begin
      state_q   <= state_d;
      // drive through the pulse and one cycle past its end
      dout_en_q <= (state_d == ST_WPULSE) || (state_q == ST_WPULSE);
      rvalid_q  <= (state_q == ST_READ) && ph_zero;
      if ((state_q == ST_READ) && ph_zero) rdata_q <= mem_din_i;
    end
  end

  assign sel           = (state_q == ST_READ) || (state_q == ST_WSETUP) ||
                         (state_q == ST_WPULSE) || (state_q == ST_WREC);
  assign ready_o       = (state_q == ST_IDLE);
  assign rvalid_o      = rvalid_q;
  assign rdata_o       = rdata_q;
  assign mem_ce1_n_o   = !sel;
  assign mem_ce2_o     = sel;
  assign mem_oe_n_o    = (state_q != ST_READ);
  assign mem_we_n_o    = (state_q != ST_WPULSE);
  assign mem_dout_o    = rq_wdata;
  assign mem_dout_en_o = dout_en_q;

  // checker-only counter of write strobe width
  logic [CW:0] we_lo_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          we_lo_cnt <= '0;
    else if (!mem_we_n_o) we_lo_cnt <= we_lo_cnt + 1'b1;
    else                  we_lo_cnt <= '0;
  end

  AST_IDLE_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (mem_ce1_n_o && !mem_ce2_o)); // R2
  AST_READY_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && req_i) |=> !ready_o); // R8
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce1_n_o && !$past(mem_ce1_n_o)) |-> $stable(mem_addr_o)); // R7
  AST_RVALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o); // R3
  AST_WE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (we_lo_cnt == (CW+1)'(N_WP))); // R4
  AST_DRIVE_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> mem_dout_en_o); // R5
  AST_DRIVE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |=> !mem_dout_en_o); // R5
  AST_NO_DRIVE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_dout_en_o && !mem_oe_n_o)); // R5
  AST_TURN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ta_busy |-> !mem_dout_en_o); // R6

endmodule

// File: tb/sram_cycle_ctl_test.sv
module sram_cycle_ctl_test;
  // expected cycle counts from R9 at 5 ns: ceil(55/5), max(ceil(40/5),ceil(25/5)), ...
  localparam int N_RD  = 11;
  localparam int N_WP  = 8;
  localparam int N_SU  = 2;
  localparam int N_REC = 1;
  localparam int N_HZ  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [18:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready, rvalid;
  logic [7:0]  rdata;
  logic [18:0] m_addr;
  logic        m_ce1_n, m_ce2, m_oe_n, m_we_n, m_den;
  logic [7:0]  m_dout;
  logic [7:0]  m_din = 8'hEE;

  int n_chk = 0, n_err = 0;
  logic [7:0] shadow [int];
  logic [7:0] mem_m  [int];
  logic [7:0] exp_q  [$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sram_cycle_ctl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .rvalid_o(rvalid), .rdata_o(rdata),
    .mem_addr_o(m_addr), .mem_ce1_n_o(m_ce1_n), .mem_ce2_o(m_ce2),
    .mem_oe_n_o(m_oe_n), .mem_we_n_o(m_we_n), .mem_dout_o(m_dout),
    .mem_dout_en_o(m_den), .mem_din_i(m_din)
  );

  task automatic check(input bit ok, input string req_tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req_tag, act, expv, $time);
    end
  endtask

  // driver: waits for ready, one-cycle request, pushes expectation
  task automatic issue(input bit w, input int a, input logic [7:0] d);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1'b1; we = w; addr = 19'(a); wdata = d;
    if (w) shadow[a] = d;
    else exp_q.push_back(shadow.exists(a) ? shadow[a] : 8'h00);
    @(negedge clk);
    req = 1'b0;
  endtask

  // memory model and protocol monitor
  int  acc = 0, hold = 0, sel_cnt = 0, we_lo = 0, post_we = 0;
  bit  prev_sel = 0, prev_we_n = 1, saw_we = 0;
  logic [18:0] prev_addr = '0;
  logic [7:0]  wlat = '0;
  always @(negedge clk) if (rst_n) begin
    bit sel, rd_act, mem_drv;
    sel    = !m_ce1_n && m_ce2;
    rd_act = sel && !m_oe_n && m_we_n;
    mem_drv = rd_act || (hold > 0);
    if (rd_act) hold = N_HZ; else if (hold > 0) hold--;
    if (m_den) check(!mem_drv, "R6 bus contention", 1, 0);
    if (ready) check(!sel, "R2 select while idle", sel, 0);
    if (sel && prev_sel) check(m_addr == prev_addr, "R7 address moved", m_addr, prev_addr);
    if (rd_act) acc = (prev_sel && m_addr == prev_addr) ? acc + 1 : 1; else acc = 0;
    m_din = (rd_act && acc >= N_RD) ? (mem_m.exists(int'(m_addr)) ? mem_m[int'(m_addr)] : 8'h00) : 8'hEE;
    if (sel && !m_we_n) begin
      saw_we = 1; we_lo++; wlat = m_dout;
      check(m_den, "R5 data not driven in pulse", m_den, 1);
    end
    if (m_we_n && !prev_we_n) begin
      check(we_lo == N_WP, "R4 R9 write pulse width", we_lo, N_WP);
      if (sel) mem_m[int'(m_addr)] = wlat;
      we_lo = 0; post_we = 1;
    end else if (post_we == 1) begin
      check(!m_den, "R5 drive not released", m_den, 0);
      post_we = 0;
    end else if (m_den && m_we_n) check(0, "R5 drive outside pulse", 1, 0);
    if (m_den && m_we_n && post_we == 1 && !(m_we_n && !prev_we_n)) ;
    if (sel) sel_cnt++;
    if (!sel && prev_sel) begin
      if (saw_we) check(sel_cnt == N_SU + N_WP + N_REC, "R4 R9 write cycle length", sel_cnt, N_SU + N_WP + N_REC);
      else        check(sel_cnt == N_RD, "R3 R9 read window length", sel_cnt, N_RD);
      sel_cnt = 0; saw_we = 0;
    end
    prev_sel = sel; prev_we_n = m_we_n; prev_addr = m_addr;
  end

  // scoreboard monitor
  always @(negedge clk) if (rst_n && rvalid) begin
    if (exp_q.size() == 0) check(0, "R8 unexpected rvalid", rdata, 0);
    else begin
      logic [7:0] e;
      e = exp_q.pop_front();
      check(rdata == e, "R3 read data", rdata, e);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ready && !rvalid && m_ce1_n && !m_ce2 && m_oe_n && m_we_n && !m_den,
          "R1 reset state", {ready, rvalid, m_ce1_n, m_ce2, m_oe_n, m_we_n, m_den}, 7'b1010110);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready && m_ce1_n && !m_ce2 && !m_den, "R1 idle after reset", ready, 1);

    issue(1, 'h00010, 8'h5A);   // R4
    issue(0, 'h00010, 8'h00);   // R3
    issue(1, 'h00000, 8'h00);   // R6: write right after read
    issue(1, 'h7FFFF, 8'hFF);
    issue(1, 'h12345, 8'hA5);
    issue(0, 'h7FFFF, 8'h00);
    issue(0, 'h00000, 8'h00);
    issue(0, 'h12345, 8'h00);

    // R8: request while busy is ignored
    issue(1, 'h00100, 8'h11);
    check(!ready, "R8 ready low while busy", ready, 0);
    req = 1'b1; we = 1'b1; addr = 19'h00200; wdata = 8'h99;
    @(negedge clk);
    req = 1'b0;
    issue(0, 'h00200, 8'h00);
    issue(0, 'h00100, 8'h00);

    // back-to-back reads and overwrite
    issue(1, 'h00010, 8'h3C);
    issue(0, 'h00010, 8'h00);
    issue(0, 'h00010, 8'h00);

    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R3 all reads returned", exp_q.size(), 0);
    check(ready && m_ce1_n && !m_den, "R2 idle at end", ready, 1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R8 watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule